// File: doc/BRIEF.md
# Framed Serial Receive Path

This block receives serial words that are aligned to a frame-sync strobe. Between frames it stays idle. When a strobe arrives on `fsync`, it waits a programmed number of bit clocks, then samples `din` once per `clk` edge into a shift register. Once the word length is reached, the word is moved into a small receive FIFO. A ready flag rises when the FIFO fill reaches a programmed threshold, and it falls again when the FIFO runs empty.

A consumer pulls words with `rd_en`. Each word comes back on a 32-bit output, justified and filled as the justification control asks. Three sticky error flags record timing faults: a word that found the FIFO full, a read of an empty FIFO, and a strobe that arrived in the middle of a word. Each flag is cleared by writing a one to its bit of `clr_flags`. Configuration inputs are meant to be held steady while frames are in flight.

Top module: `frame_rx`

## Requirements
- R1: While no strobe has been seen, activity on `din` puts nothing into the FIFO and `rdy` stays low.
- R2: With `dly_code` 0, 1 or 2, the first data bit is sampled that many clocks after the clock in which `fsync` is high. Code 0 samples it in the strobe clock itself. Code 3 behaves as code 2.
- R3: Bits arrive MSB first. `len_code` picks the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 and 7 give 32.
- R4: A completed word enters the FIFO only if the FIFO is not full. The FIFO holds `DEPTH` words, and they are read out in arrival order.
- R5: `rdy` rises in the clock where the fill count reaches `thresh` (a value of 0 acts as 1). It stays high through reads until the FIFO is empty.
- R6: `rd_data` is updated one clock after a read of a non-empty FIFO. `just_code` selects the format: 0 is right-justified with the upper bits zero; 1 is right-justified with the sign bit extended; 2 is left-justified with the lower bits zero. Code 3 behaves as code 0.
- R7: A word that completes while the FIFO is full is discarded, and the sticky `ovr_flag` is set.
- R8: A read of an empty FIFO leaves `rd_data` unchanged and sets the sticky `unf_flag`.
- R9: A strobe that arrives while a delay or word is in progress sets the sticky `fserr_flag`. It drops the partial word and restarts reception, with the data delay applied.
- R10: A one on `clr_flags` bit 0 clears `ovr_flag`, bit 1 clears `unf_flag` and bit 2 clears `fserr_flag`. A new error in the same clock wins over the clear.
- R11: After reset the FIFO is empty, `rdy` and all three flags are low, and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame-sync strobe, one clock wide |
| din | input | 1 | Serial data input |
| dly_code | input | 2 | Data delay selection |
| len_code | input | 3 | Word length selection |
| just_code | input | 2 | Readout justification and fill selection |
| thresh | input | CW | FIFO fill level that raises ready |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Justified word from the last read |
| rdy | output | 1 | Receive ready flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| unf_flag | output | 1 | Sticky underflow flag |
| fserr_flag | output | 1 | Sticky unexpected frame-sync flag |
| clr_flags | input | 3 | Write-one-to-clear for the three flags |

## Verification
The hardest case to reach from the ports is a strobe that lands in the middle of a word. The driver starts a frame, sends only a few bits, and then opens a new frame. The bench then checks that exactly the second word reaches the FIFO and that the fragment is gone. The overrun case is also demanding. The bench fills the FIFO to `DEPTH` and sends one more frame. It then reads back the stored words and checks that the extra word never took a slot and that arrival order was kept.

// File: rtl/frame_rx.sv
module frame_rx #(
  parameter int DEPTH = 4,
  parameter int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          din,
  input  logic [1:0]    dly_code,
  input  logic [2:0]    len_code,
  input  logic [1:0]    just_code,
  input  logic [CW-1:0] thresh,
  input  logic          rd_en,
  output logic [31:0]   rd_data,
  output logic          rdy,
  output logic          ovr_flag,
  output logic          unf_flag,
  output logic          fserr_flag,
  input  logic [2:0]    clr_flags
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_DLY, S_SHIFT} st_t;

  st_t          st;
  logic [1:0]   dcnt;
  logic [5:0]   bcnt;
  logic [31:0]  sr;
  logic [31:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, cnt_nxt, thr_eff;

  logic [5:0]  wlen;
  logic [1:0]  dly_eff;
  logic [31:0] word, head, just_val;
  logic [4:0]  sh;
  logic        last, full, empty, push, pop, ovr_set, unf_set, fs_set;

  always_comb begin
    case (len_code)
      3'd0:    wlen = 6'd8;
      3'd1:    wlen = 6'd12;
      3'd2:    wlen = 6'd16;
      3'd3:    wlen = 6'd20;
      3'd4:    wlen = 6'd24;
      default: wlen = 6'd32;
    endcase
  end

  assign dly_eff = (dly_code == 2'd3) ? 2'd2 : dly_code;
  assign word    = {sr[30:0], din};
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign last    = (st == S_SHIFT) && !fsync && (bcnt == wlen - 6'd1);
  assign push    = last && !full;
  assign ovr_set = last && full;
  assign fs_set  = fsync && (st != S_IDLE);
  assign pop     = rd_en && !empty;
  assign unf_set = rd_en && empty;
  assign cnt_nxt = count + CW'(push) - CW'(pop);
  assign thr_eff = (thresh == '0) ? CW'(1) : thresh;

  // bit capture and framing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      dcnt <= '0;
      bcnt <= '0;
      sr   <= '0;
    end else if (fsync) begin
      if (dly_eff == 2'd0) begin
        st   <= S_SHIFT;
        sr   <= {31'b0, din};
        bcnt <= 6'd1;
      end else begin
        st   <= S_DLY;
        dcnt <= dly_eff - 2'd1;
        sr   <= '0;
      end
    end else begin
      case (st)
        S_DLY: begin
          if (dcnt == 2'd0) begin
            st   <= S_SHIFT;
            sr   <= {31'b0, din};
            bcnt <= 6'd1;
          end else begin
            dcnt <= dcnt - 2'd1;
          end
        end
        S_SHIFT: begin
          sr   <= word;
          bcnt <= bcnt + 6'd1;
          if (last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // receive buffer
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      rdy   <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      count <= cnt_nxt;
      if (cnt_nxt == '0)          rdy <= 1'b0;
      else if (cnt_nxt >= thr_eff) rdy <= 1'b1;
    end
  end

  // readout justification
  assign head = mem[rptr];
  assign sh   = 5'(6'd32 - wlen);
  always_comb begin
    case (just_code)
      2'd1:    just_val = 32'($signed(head << sh) >>> sh);
      2'd2:    just_val = head << sh;
      default: just_val = head;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rd_data <= '0;
    else if (pop) rd_data <= just_val;
  end

  // sticky error flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag   <= 1'b0;
      unf_flag   <= 1'b0;
      fserr_flag <= 1'b0;
    end else begin
      if (ovr_set)           ovr_flag <= 1'b1;
      else if (clr_flags[0]) ovr_flag <= 1'b0;
      if (unf_set)           unf_flag <= 1'b1;
      else if (clr_flags[1]) unf_flag <= 1'b0;
      if (fs_set)            fserr_flag <= 1'b1;
      else if (clr_flags[2]) fserr_flag <= 1'b0;
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r5_rdy_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> count != '0);
  a_r7_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> $past(count) == CW'(DEPTH));
  a_r8_unf_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && count == '0) |=> ($stable(rd_data) && unf_flag));
  a_r9_fserr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fsync && st != S_IDLE) |=> fserr_flag);
  a_r1_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !fsync) |=> st == S_IDLE);
endmodule

// File: tb/frame_rx_tb_top.sv
`timescale 1ns/1ps
module frame_rx_tb_top;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, fsync = 0, din = 0, rd_en = 0;
  logic [1:0] dly_code = 0, just_code = 0;
  logic [2:0] len_code = 0, clr_flags = 0;
  logic [CW-1:0] thresh = 1;
  logic [31:0] rd_data;
  logic rdy, ovr_flag, unf_flag, fserr_flag;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  logic [31:0] last_val = 0;
  string req_q[$];

  always #2 clk = ~clk;

  frame_rx #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .din(din),
    .dly_code(dly_code), .len_code(len_code), .just_code(just_code),
    .thresh(thresh), .rd_en(rd_en), .rd_data(rd_data), .rdy(rdy),
    .ovr_flag(ovr_flag), .unf_flag(unf_flag), .fserr_flag(fserr_flag),
    .clr_flags(clr_flags));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] lcode(input int len);
    case (len)
      8: return 3'd0; 12: return 3'd1; 16: return 3'd2;
      20: return 3'd3; 24: return 3'd4; default: return 3'd5;
    endcase
  endfunction

  function automatic logic [31:0] jv(input logic [31:0] w, input int len, input int j);
    logic [31:0] m;
    m = (len == 32) ? w : (w & ((32'd1 << len) - 32'd1));
    if (j == 1 && len < 32 && m[len-1]) return m | ~((32'd1 << len) - 32'd1);
    if (j == 2) return m << (32 - len);
    return m;
  endfunction

  task automatic frame(input logic [31:0] w, input int len, input int dcode);
    int d;
    d = (dcode == 3) ? 2 : dcode;
    dly_code = 2'(dcode);
    len_code = lcode(len);
    for (int c = 0; c < d + len; c++) begin
      @(negedge clk);
      fsync = (c == 0);
      din = (c >= d) ? w[len-1-(c-d)] : 1'b0;
    end
    @(negedge clk);
    fsync = 0; din = 0;
  endtask

  task automatic rd(input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_en = 1;
    exp_q.push_back(exp);
    req_q.push_back(req);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic clr(input logic [2:0] m);
    @(negedge clk);
    clr_flags = m;
    @(negedge clk);
    clr_flags = 0;
  endtask

  // scoreboard monitor
  initial begin
    logic sampled;
    forever begin
      @(posedge clk);
      sampled = rd_en;
      #1;
      if (sampled) begin
        if (exp_q.size() == 0) chk(1, 0, "R6 unexpected read");
        else chk(rd_data, exp_q.pop_front(), req_q.pop_front());
      end
    end
  end

  initial begin
    #400us;
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rd_data, 0, "R11 rd_data");
    chk({rdy, ovr_flag, unf_flag, fserr_flag}, 0, "R11 flags");
    rst_n = 1;
    @(negedge clk);

    // R1 no strobe: noise ignored
    for (int i = 0; i < 40; i++) begin @(negedge clk); din = i[0] ^ i[2]; end
    din = 0;
    @(negedge clk);
    chk(rdy, 0, "R1 rdy after noise");

    // R2 R3 R5 threshold of two, delay 1 and 0, 8-bit
    thresh = 2; just_code = 0;
    frame(32'hA5, 8, 1);
    chk(rdy, 0, "R5 below threshold");
    frame(32'h3C, 8, 0);
    chk(rdy, 1, "R5 at threshold");
    rd(32'hA5, "R2 R3 delay1 word");
    @(negedge clk);
    chk(rdy, 1, "R5 held through read");
    rd(32'h3C, "R2 delay0 word");
    @(negedge clk);
    chk(rdy, 0, "R5 cleared on empty");

    // R6 justification modes, R2 code 3
    thresh = 1;
    just_code = 1;
    frame(32'h8001, 16, 2);
    rd(jv(32'h8001, 16, 1), "R6 sign 16");
    just_code = 2;
    frame(32'hABC, 12, 3);
    rd(jv(32'hABC, 12, 2), "R2 R6 code3 left 12");
    just_code = 0;
    frame(32'hDEADBEEF, 32, 1);
    rd(32'hDEADBEEF, "R3 R6 32-bit");
    just_code = 1;
    frame(32'h7FFFFF, 24, 0);
    rd(jv(32'h7FFFFF, 24, 1), "R6 sign positive 24");
    frame(32'h80000, 20, 1);
    rd(jv(32'h80000, 20, 1), "R6 sign negative 20");
    just_code = 3;
    frame(32'h5A, 8, 2);
    rd(32'h5A, "R6 code3 right");
    just_code = 0;

    // R7 overrun: fifth word dropped
    for (int i = 0; i < DEPTH; i++) frame(32'h10 + 32'(i), 8, 1);
    chk(ovr_flag, 0, "R7 no overrun at full");
    frame(32'hEE, 8, 1);
    chk(ovr_flag, 1, "R7 overrun flag");
    chk(rdy, 1, "R5 rdy when full");
    for (int i = 0; i < DEPTH; i++) rd(32'h10 + 32'(i), "R4 R7 order kept");
    last_val = 32'h10 + 32'(DEPTH - 1);

    // R8 underflow
    rd(last_val, "R8 empty read holds");
    @(negedge clk);
    chk(unf_flag, 1, "R8 underflow flag");
    chk(ovr_flag, 1, "R7 overrun sticky");

    // R10 clear
    clr(3'b001);
    chk({ovr_flag, unf_flag}, 2'b01, "R10 clear ovr only");
    clr(3'b010);
    chk(unf_flag, 0, "R10 clear unf");

    // R9 unexpected strobe mid-word
    dly_code = 1; len_code = lcode(8);
    @(negedge clk); fsync = 1; din = 1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); fsync = 0; din = 1; end
    frame(32'h42, 8, 1);
    chk(fserr_flag, 1, "R9 fserr flag");
    rd(32'h42, "R9 restarted word");
    @(negedge clk);
    chk(rdy, 0, "R9 partial word dropped");
    rd(32'h42, "R9 only one word");
    clr(3'b100);
    chk(fserr_flag, 0, "R10 clear fserr");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule